// File: doc/BRIEF.md
# Fractional-N Divider Sequencer

This block drives a dual-modulus main divider running on the VCO clock. At every divider cycle boundary a small fractional accumulator adds a programmed numerator, wrapping at a modulus of either 5 or 8. When the add wraps, the next divider period lasts N+1 VCO cycles. Otherwise it lasts N. Averaged over many periods, the division ratio therefore equals N plus the numerator over the modulus.

Alongside the divider pulse, the block times a compensation window of fixed length at the start of each period. It also supplies a digital magnitude code equal to the accumulator residue multiplied by an 8-bit DAC code. A downstream current source scales its injected charge with this code. For the code to track the ripple, the DAC code is normally 128 with modulus 5 and 80 with modulus 8.

All programming inputs are sampled only at a period boundary, so retuning never shortens or stretches a period already under way.

Top module: `fracn_seq`

## Requirements
- R1: While the synchronous active-high reset is high, `div_pulse`, `comp_win` and `comp_mag` read 0, the accumulator holds 0 and the stored modulus is modulo 8. The first period starts at the first rising edge with reset low.
- R2: `div_pulse` is high for exactly one VCO cycle, the last cycle of each divider period. A period lasts as many VCO cycles as the ratio loaded at its start.
- R3: At every boundary the accumulator adds the numerator, wrapping modulo 5 when `mod5_sel`=1 and modulo 8 when `mod5_sel`=0. The period that follows a wrapping add lasts N+1 cycles; the period that follows any other add lasts N cycles.
- R4: A numerator greater than or equal to the selected modulus is used as modulus-1. For example, 7 with modulo 5 adds 4.
- R5: `n_int` is sampled only at a boundary. A value below 512 is used as 512, and values up to 65535 are honoured.
- R6: If `mod5_sel` at a boundary differs from the value stored at the previous boundary, the accumulator restarts from 0 before the add.
- R7: `comp_win` is high for exactly 128 consecutive VCO cycles, starting in the first cycle of every period, and is low at every `div_pulse`.
- R8: At each boundary, `comp_mag` takes the new accumulator residue times `dac_code` (both unsigned). It holds that value for the rest of the period.
- R9: Changes to `num`, `mod5_sel` or `dac_code` between boundaries have no effect on any output until the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | VCO clock |
| rst | input | 1 | Synchronous active-high reset |
| n_int | input | 16 | Integer divide ratio N |
| num | input | 3 | Fractional numerator |
| mod5_sel | input | 1 | 1 selects modulo 5, 0 selects modulo 8 |
| dac_code | input | 8 | Compensation scale code |
| div_pulse | output | 1 | Divider output pulse at terminal count |
| comp_win | output | 1 | Compensation window strobe |
| comp_mag | output | 11 | Compensation magnitude code |

## Verification
`div_pulse` is decoded from the period counter, so it is high in the same cycle as the counter's last state. The boundary edge that ends that cycle loads the new ratio, the accumulator, `comp_mag` and the window counter. As a result, the window and the new magnitude both appear in the cycle right after the pulse, and any input change shows up only after the next pulse. The bench reference model applies inputs at the same boundary edge and compares all three outputs at every falling edge. This means each result is checked in exactly the cycle it is due, including the 128-cycle window edges and the periods of N+1 cycles.

// File: rtl/fracn_pkg.sv
package fracn_pkg;

    localparam int ACC_W = 3;
    localparam int NUM_W = 3;

    typedef struct packed {
        logic             carry;
        logic [ACC_W-1:0] residue;
    } acc_step_t;

    function automatic logic [3:0] modulus(input logic mod5);
        return mod5 ? 4'd5 : 4'd8;
    endfunction

    function automatic logic [NUM_W-1:0] clamp_num(input logic [NUM_W-1:0] num,
                                                   input logic mod5);
        logic [3:0] m;
        m = modulus(mod5);
        if ({1'b0, num} >= m) return NUM_W'(m - 4'd1);
        return num;
    endfunction

endpackage

// File: rtl/fracn_acc.sv
module fracn_acc
    import fracn_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic [NUM_W-1:0] num,
    input  logic             mod5_sel,
    output acc_step_t        nxt,
    output logic [ACC_W-1:0] acc_q,
    output logic             mod5_q
);

    logic [3:0] m;
    logic [3:0] base;
    logic [3:0] sum;

    always_comb begin
        m            = modulus(mod5_sel);
        base         = (mod5_sel != mod5_q) ? 4'd0 : {1'b0, acc_q};
        sum          = base + {1'b0, clamp_num(num, mod5_sel)};
        nxt.carry    = (sum >= m);
        nxt.residue  = nxt.carry ? ACC_W'(sum - m) : ACC_W'(sum);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            mod5_q <= 1'b0;
        end else if (step) begin
            acc_q  <= nxt.residue;
            mod5_q <= mod5_sel;
        end
    end

endmodule

// File: rtl/fracn_divcnt.sv
module fracn_divcnt #(
    parameter int N_W   = 16,
    parameter int N_MIN = 512
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [N_W-1:0] n_int,
    input  logic           carry,
    output logic           reload,
    output logic           div_pulse
);

    localparam int CNT_W = N_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] ratio;

    always_comb begin
        ratio     = ((n_int < N_W'(N_MIN)) ? CNT_W'(N_MIN) : {1'b0, n_int})
                    + CNT_W'(carry);
        reload    = (cnt_q <= CNT_W'(1));
        div_pulse = (cnt_q == CNT_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst)         cnt_q <= '0;
        else if (reload) cnt_q <= ratio;
        else             cnt_q <= cnt_q - CNT_W'(1);
    end

endmodule

// File: rtl/fracn_comp.sv
module fracn_comp
    import fracn_pkg::*;
#(
    parameter int DAC_W   = 8,
    parameter int WIN_LEN = 128
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   reload,
    input  logic [ACC_W-1:0]       residue,
    input  logic [DAC_W-1:0]       dac_code,
    output logic                   comp_win,
    output logic [ACC_W+DAC_W-1:0] comp_mag
);

    localparam int MAG_W = ACC_W + DAC_W;
    localparam int WC_W  = $clog2(WIN_LEN + 1);
    localparam logic [WC_W-1:0] WIN_END = WC_W'(WIN_LEN);

    logic [WC_W-1:0] win_q;

    assign comp_win = (win_q < WIN_END);

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q    <= WIN_END;
            comp_mag <= '0;
        end else if (reload) begin
            win_q    <= '0;
            comp_mag <= MAG_W'(residue) * MAG_W'(dac_code);
        end else if (win_q < WIN_END) begin
            win_q    <= win_q + WC_W'(1);
        end
    end

endmodule

// File: rtl/fracn_seq.sv
module fracn_seq
    import fracn_pkg::*;
#(
    parameter int N_W     = 16,
    parameter int N_MIN   = 512,
    parameter int DAC_W   = 8,
    parameter int WIN_LEN = 128
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [N_W-1:0]         n_int,
    input  logic [NUM_W-1:0]       num,
    input  logic                   mod5_sel,
    input  logic [DAC_W-1:0]       dac_code,
    output logic                   div_pulse,
    output logic                   comp_win,
    output logic [ACC_W+DAC_W-1:0] comp_mag
);

    acc_step_t        nxt;
    logic [ACC_W-1:0] acc_q;
    logic             mod5_q;
    logic             reload;

    fracn_acc u_acc (
        .clk      (clk),
        .rst      (rst),
        .step     (reload),
        .num      (num),
        .mod5_sel (mod5_sel),
        .nxt      (nxt),
        .acc_q    (acc_q),
        .mod5_q   (mod5_q)
    );

    fracn_divcnt #(.N_W(N_W), .N_MIN(N_MIN)) u_div (
        .clk       (clk),
        .rst       (rst),
        .n_int     (n_int),
        .carry     (nxt.carry),
        .reload    (reload),
        .div_pulse (div_pulse)
    );

    fracn_comp #(.DAC_W(DAC_W), .WIN_LEN(WIN_LEN)) u_comp (
        .clk      (clk),
        .rst      (rst),
        .reload   (reload),
        .residue  (nxt.residue),
        .dac_code (dac_code),
        .comp_win (comp_win),
        .comp_mag (comp_mag)
    );

endmodule

// File: rtl/fracn_seq_chk.sv
module fracn_seq_chk #(
    parameter int ACC_W = 3,
    parameter int MAG_W = 11
) (
    input logic             clk,
    input logic             rst,
    input logic             div_pulse,
    input logic             comp_win,
    input logic [MAG_W-1:0] comp_mag,
    input logic             reload,
    input logic [ACC_W-1:0] acc_q,
    input logic             mod5_q
);

    // R2: pulse lasts one cycle
    a_r2_pulse_single: assert property (@(posedge clk) disable iff (rst)
        div_pulse |=> !div_pulse);

    // R7: window opens right after the pulse
    a_r7_win_after_pulse: assert property (@(posedge clk) disable iff (rst)
        div_pulse |=> comp_win);

    // R7: window is closed at terminal count
    a_r7_win_closed_at_pulse: assert property (@(posedge clk) disable iff (rst)
        div_pulse |-> !comp_win);

    // R8: magnitude only moves at a boundary
    a_r8_mag_hold: assert property (@(posedge clk) disable iff (rst)
        !reload |=> $stable(comp_mag));

    // R3: residue stays below modulo 5 when that modulus is in use
    a_r3_acc_bound: assert property (@(posedge clk) disable iff (rst)
        mod5_q |-> (acc_q < ACC_W'(5)));

endmodule

bind fracn_seq fracn_seq_chk #(.ACC_W(fracn_pkg::ACC_W), .MAG_W(fracn_pkg::ACC_W + DAC_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .div_pulse (div_pulse),
    .comp_win  (comp_win),
    .comp_mag  (comp_mag),
    .reload    (reload),
    .acc_q     (acc_q),
    .mod5_q    (mod5_q)
);

// File: tb/fracn_seq_bench.sv
`timescale 1ns/1ps
module fracn_seq_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] n_int = 16'd600;
    logic [2:0]  num = 3'd0;
    logic        mod5_sel = 1'b0;
    logic [7:0]  dac_code = 8'd0;
    logic        div_pulse;
    logic        comp_win;
    logic [10:0] comp_mag;

    always #5 clk = ~clk;

    fracn_seq u_fracn_seq (
        .clk       (clk),
        .rst       (rst),
        .n_int     (n_int),
        .num       (num),
        .mod5_sel  (mod5_sel),
        .dac_code  (dac_code),
        .div_pulse (div_pulse),
        .comp_win  (comp_win),
        .comp_mag  (comp_mag)
    );

    int    checks = 0;
    int    errors = 0;
    string phase  = "R1";
    bit    started = 0;
    bit    done    = 0;

    // behavioural reference model
    int m_cnt = 0, m_acc = 0, m_prev5 = 0, m_win = 128, m_mag = 0;

    always @(posedge clk) begin
        int nn, nm, a, k, s, c;
        started = 1;
        if (rst) begin
            m_cnt = 0; m_acc = 0; m_prev5 = 0; m_win = 128; m_mag = 0;
        end else if (m_cnt <= 1) begin
            nn = (int'(n_int) < 512) ? 512 : int'(n_int);
            nm = mod5_sel ? 5 : 8;
            a  = (int'(mod5_sel) != m_prev5) ? 0 : m_acc;
            k  = (int'(num) >= nm) ? nm - 1 : int'(num);
            s  = a + k;
            c  = 0;
            if (s >= nm) begin s = s - nm; c = 1; end
            m_acc = s; m_prev5 = int'(mod5_sel);
            m_cnt = nn + c; m_win = 0; m_mag = s * int'(dac_code);
        end else begin
            m_cnt = m_cnt - 1;
            if (m_win < 128) m_win = m_win + 1;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started && !done) begin
            chk({phase, "/R2"}, "div_pulse", int'(div_pulse), (m_cnt == 1) ? 1 : 0);
            chk({phase, "/R7"}, "comp_win",  int'(comp_win),  (m_win < 128) ? 1 : 0);
            chk({phase, "/R8"}, "comp_mag",  int'(comp_mag),  m_mag);
        end
    end

    task automatic run(input int cycles);
        repeat (cycles) @(negedge clk);
    endtask

    task automatic wait_pulse();
        do @(negedge clk); while (!div_pulse);
    endtask

    initial begin
        phase = "R1";
        run(4);
        rst = 1'b0;

        phase = "R3";
        mod5_sel = 1'b1; num = 3'd2; dac_code = 8'd128;
        run(6100);

        phase = "R6";
        mod5_sel = 1'b0; num = 3'd3; dac_code = 8'd80;
        run(5200);

        phase = "R4";
        mod5_sel = 1'b1; num = 3'd7;
        run(4200);

        phase = "R5";
        n_int = 16'd100;
        run(3100);
        wait_pulse();
        run(77);
        n_int = 16'd700;
        run(4300);

        phase = "R9";
        wait_pulse();
        run(50);
        num = 3'd1; dac_code = 8'd200; mod5_sel = 1'b0;
        run(3000);

        phase = "R8";
        num = 3'd0; dac_code = 8'd255;
        run(2000);
        mod5_sel = 1'b1; num = 3'd4;
        run(3000);

        phase = "R1";
        rst = 1'b1;
        run(3);
        rst = 1'b0;
        run(2000);

        phase = "R2";
        n_int = 16'd65535; mod5_sel = 1'b0; num = 3'd7;
        run(133000);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        done = 1;
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule